// File: doc/BRIEF.md
# Fully Associative Tag Store with Not-Most-Recently-Used Victim Pointer

This block holds a table of tags, each with a valid bit, and finds a tag in any entry of the table. A lookup compares the presented key against every entry in the same cycle. It returns a hit flag and the binary number of the matching entry within that cycle. An allocate request writes a new tag into a chosen entry at the next clock edge. A single invalidate-all pulse empties the table.

The victim is chosen with one rotating pointer, and no age history is kept. The pointer steps forward by one entry only when the entry it currently names is touched, either by a lookup hit or by an allocation. The entry the pointer names is therefore never the one used most recently. While the table still has empty entries, allocation fills the lowest-numbered empty entry and does not use the pointer. The caller keeps the stored tags unique, so at most one entry can match a key.

Top module: `nmru_tag_store`

## Requirements
- R1: After reset every entry is invalid, `victim_ptr` is 0, `hit` is 0 and `alloc_idx` is 0.
- R2: While `lookup_vld` is 1 and a valid entry holds a tag equal to `lookup_tag`, `hit` is 1 and `hit_idx` gives that entry's number in the same cycle. When no valid entry matches, or when `lookup_vld` is 0, `hit` is 0.
- R3: While any entry is invalid, `alloc_idx` is the lowest-numbered invalid entry. An allocation writes `alloc_tag` there and marks the entry valid at the clock edge.
- R4: While every entry is valid, `alloc_idx` equals `victim_ptr`, and an allocation replaces the tag in that entry.
- R5: An allocation into the entry that `victim_ptr` names advances the pointer by one. An allocation into any other entry leaves the pointer unchanged.
- R6: A lookup hit on the entry that `victim_ptr` names advances the pointer by one at the clock edge.
- R7: A lookup hit on any other entry, a lookup miss, or an idle cycle leaves `victim_ptr` unchanged.
- R8: The pointer advances from entry 63, the last entry, to entry 0.
- R9: A cycle with `inv_all` at 1 makes every entry invalid at the edge and leaves `victim_ptr` unchanged. In that cycle `inv_all` overrides any allocation, which then writes nothing.
- R10: At most one entry matches a key. `hit_idx` is the binary number of the single matching entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lookup_vld | input | 1 | Lookup request |
| lookup_tag | input | TAG_W | Key compared with all entries |
| hit | output | 1 | A valid entry matches the key |
| hit_idx | output | IDX_W | Number of the matching entry |
| alloc_vld | input | 1 | Install `alloc_tag` at `alloc_idx` |
| alloc_tag | input | TAG_W | Tag to install |
| alloc_idx | output | IDX_W | Entry the next allocation will use |
| inv_all | input | 1 | Clear every valid bit |
| victim_ptr | output | IDX_W | Current replacement pointer |

## Verification
`hit`, `hit_idx` and `alloc_idx` depend combinationally on the stored state and the present inputs. The bench therefore drives inputs after a falling edge and reads these outputs 1 ns later, before the next rising edge. Table contents and `victim_ptr` change at the rising edge that takes the request. The bench reads them at the following falling edge, one cycle after the stimulus, and compares them with a pointer model it keeps itself. Lookups that follow an allocation or an invalidation run in a later cycle, so they see the updated table.

// File: rtl/nmru_pkg.sv
package nmru_pkg;
  // Reason the pointer moves on a given cycle
  typedef enum logic [1:0] {
    PTR_KEEP  = 2'd0,
    PTR_ALLOC = 2'd1,
    PTR_HIT   = 2'd2
  } ptr_cause_e;
endpackage

// File: rtl/nmru_match.sv
module nmru_match #(
  parameter int N     = 64,
  parameter int TAG_W = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic [TAG_W-1:0]           key,
  input  logic [N-1:0]               valid,
  input  logic [N-1:0][TAG_W-1:0]    tags,
  output logic [N-1:0]               match_vec,
  output logic                       hit,
  output logic [IDX_W-1:0]           hit_idx
);
  // OR-encode a one-hot vector into a binary index
  function automatic logic [IDX_W-1:0] onehot_enc(input logic [N-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < N; i++)
      if (v[i]) r = r | IDX_W'(i);
    return r;
  endfunction

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_vec[g] = en && valid[g] && (tags[g] == key);
  end

  assign hit     = |match_vec;
  assign hit_idx = onehot_enc(match_vec);

  AST_HIT_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec)); // R10
endmodule

// File: rtl/nmru_free_pick.sv
module nmru_free_pick #(
  parameter int N     = 64,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     valid,
  output logic             any_free,
  output logic [IDX_W-1:0] free_idx
);
  function automatic logic [IDX_W-1:0] lowest_zero(input logic [N-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--)
      if (!v[i]) r = IDX_W'(i);
    return r;
  endfunction

  assign any_free = ~&valid;
  assign free_idx = lowest_zero(valid);
endmodule

// File: rtl/nmru_ptr.sv
module nmru_ptr #(
  parameter int N     = 64,
  parameter int IDX_W = $clog2(N)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  nmru_pkg::ptr_cause_e    cause,
  output logic [IDX_W-1:0]        ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  function automatic logic [IDX_W-1:0] ptr_next(input logic [IDX_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  logic step;
  assign step = (cause != nmru_pkg::PTR_KEEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= '0;
    else if (step) ptr <= ptr_next(ptr);
  end

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1))); // R6
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && ptr == LAST) |=> (ptr == '0)); // R8
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(ptr)); // R7
endmodule

// File: rtl/nmru_tag_store.sv
module nmru_tag_store #(
  parameter int N     = 64,
  parameter int TAG_W = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lookup_vld,
  input  logic [TAG_W-1:0] lookup_tag,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx,
  input  logic             alloc_vld,
  input  logic [TAG_W-1:0] alloc_tag,
  output logic [IDX_W-1:0] alloc_idx,
  input  logic             inv_all,
  output logic [IDX_W-1:0] victim_ptr
);
  import nmru_pkg::*;

  logic [N-1:0]            valid_q;
  logic [N-1:0][TAG_W-1:0] tag_q;
  logic [N-1:0]            match_vec;
  logic                    any_free;
  logic [IDX_W-1:0]        free_idx;
  logic                    alloc_fire;
  logic                    alloc_on_ptr;
  logic                    hit_on_ptr;
  ptr_cause_e              cause;

  nmru_match #(.N(N), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_match (
    .clk(clk), .rst_n(rst_n), .en(lookup_vld), .key(lookup_tag),
    .valid(valid_q), .tags(tag_q), .match_vec(match_vec),
    .hit(hit), .hit_idx(hit_idx));

  nmru_free_pick #(.N(N), .IDX_W(IDX_W)) u_free (
    .valid(valid_q), .any_free(any_free), .free_idx(free_idx));

  assign alloc_idx    = any_free ? free_idx : victim_ptr;
  assign alloc_fire   = alloc_vld && !inv_all;
  assign alloc_on_ptr = alloc_fire && (alloc_idx == victim_ptr);
  assign hit_on_ptr   = !inv_all && hit && (hit_idx == victim_ptr);

  always_comb begin
    if (alloc_on_ptr)    cause = PTR_ALLOC;
    else if (hit_on_ptr) cause = PTR_HIT;
    else                 cause = PTR_KEEP;
  end

  nmru_ptr #(.N(N), .IDX_W(IDX_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .cause(cause), .ptr(victim_ptr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      tag_q   <= '0;
    end else if (inv_all) begin
      valid_q <= '0;
    end else if (alloc_fire) begin
      valid_q[alloc_idx] <= 1'b1;
      tag_q[alloc_idx]   <= alloc_tag;
    end
  end

  AST_INV_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (valid_q == '0)); // R9
  AST_INV_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> $stable(victim_ptr)); // R9
  AST_ALLOC_SET: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |=> valid_q[$past(alloc_idx)]); // R3
  AST_ALLOC_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (&valid_q) |-> (alloc_idx == victim_ptr)); // R4
  AST_ALLOC_OFF_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_fire && alloc_idx != victim_ptr && !hit_on_ptr) |=> $stable(victim_ptr)); // R5
endmodule

// File: tb/nmru_tag_store_test.sv
`timescale 1ns/1ps
module nmru_tag_store_test;
  localparam int N = 64, TAG_W = 16, IDX_W = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lookup_vld = 1'b0, alloc_vld = 1'b0, inv_all = 1'b0;
  logic [TAG_W-1:0] lookup_tag = '0, alloc_tag = '0;
  logic hit;
  logic [IDX_W-1:0] hit_idx, alloc_idx, victim_ptr;
  int checks = 0, fails = 0;
  int exp_ptr = 0;

  always #2.5 clk = ~clk;

  nmru_tag_store #(.N(N), .TAG_W(TAG_W)) uut (
    .clk(clk), .rst_n(rst_n), .lookup_vld(lookup_vld), .lookup_tag(lookup_tag),
    .hit(hit), .hit_idx(hit_idx), .alloc_vld(alloc_vld), .alloc_tag(alloc_tag),
    .alloc_idx(alloc_idx), .inv_all(inv_all), .victim_ptr(victim_ptr));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Present a lookup, check comb result, clock it in
  task automatic do_lookup(input logic [TAG_W-1:0] t, input bit exp_hit,
                           input int exp_idx, input string req);
    @(negedge clk);
    lookup_vld = 1'b1; lookup_tag = t;
    #1;
    chk(req, hit, exp_hit);
    if (exp_hit) chk(req, hit_idx, exp_idx);
    if (exp_hit && exp_idx == exp_ptr) exp_ptr = (exp_ptr + 1) % N;
    @(posedge clk);
    @(negedge clk);
    lookup_vld = 1'b0;
  endtask

  task automatic do_alloc(input logic [TAG_W-1:0] t, input int exp_idx, input string req);
    @(negedge clk);
    alloc_vld = 1'b1; alloc_tag = t;
    #1;
    chk(req, alloc_idx, exp_idx);
    if (exp_idx == exp_ptr) exp_ptr = (exp_ptr + 1) % N;
    @(posedge clk);
    @(negedge clk);
    alloc_vld = 1'b0;
  endtask

  task automatic test_reset();
    #1;
    chk("R1 hit", hit, 0);
    chk("R1 ptr", victim_ptr, 0);
    chk("R1 alloc_idx", alloc_idx, 0);
    do_lookup(16'h0000, 1'b0, 0, "R1 empty lookup");
  endtask

  task automatic test_fill();
    for (int i = 0; i < N; i++) begin
      do_alloc(16'h1000 + 16'(i), i, "R3 fill index");
      chk("R5 ptr after fill step", victim_ptr, exp_ptr);
    end
    chk("R8 ptr wrapped by fill", victim_ptr, 0);
  endtask

  task automatic test_lookup();
    do_lookup(16'h1005, 1'b1, 5, "R2 hit entry 5");
    chk("R7 off-ptr hit holds", victim_ptr, 0);
    do_lookup(16'h2000, 1'b0, 0, "R2 miss");
    chk("R7 miss holds", victim_ptr, 0);
    @(negedge clk);
    lookup_tag = 16'h1007; lookup_vld = 1'b0;
    #1; chk("R2 idle no hit", hit, 0);
    do_lookup(16'h1000, 1'b1, 0, "R6 hit at ptr");
    chk("R6 ptr step 1", victim_ptr, 1);
    do_lookup(16'h1001, 1'b1, 1, "R6 hit at ptr");
    chk("R6 ptr step 2", victim_ptr, 2);
    do_lookup(16'h103F, 1'b1, 63, "R10 top entry index");
    chk("R7 ptr held", victim_ptr, 2);
  endtask

  task automatic test_replace();
    do_alloc(16'h3000, 2, "R4 victim at ptr");
    chk("R5 ptr after replace", victim_ptr, 3);
    do_lookup(16'h3000, 1'b1, 2, "R4 new tag found");
    do_lookup(16'h1002, 1'b0, 0, "R4 old tag gone");
  endtask

  task automatic test_wrap();
    for (int i = 3; i < N; i++) do_lookup(16'h1000 + 16'(i), 1'b1, i, "R6 walk");
    chk("R8 ptr wrapped", victim_ptr, 0);
    do_lookup(16'h1000, 1'b1, 0, "R6 hit after wrap");
    chk("R6 ptr 1", victim_ptr, 1);
  endtask

  task automatic test_inv();
    @(negedge clk);
    inv_all = 1'b1; alloc_vld = 1'b1; alloc_tag = 16'h5555;
    @(posedge clk);
    @(negedge clk);
    inv_all = 1'b0; alloc_vld = 1'b0;
    chk("R9 ptr kept", victim_ptr, 1);
    #1; chk("R9 alloc_idx empty", alloc_idx, 0);
    do_lookup(16'h1005, 1'b0, 0, "R9 cleared");
    do_lookup(16'h5555, 1'b0, 0, "R9 alloc dropped");
    do_alloc(16'h4000, 0, "R3 lowest free");
    chk("R5 off-ptr alloc holds", victim_ptr, 1);
    do_alloc(16'h4001, 1, "R3 next free");
    chk("R5 on-ptr alloc steps", victim_ptr, 2);
    do_lookup(16'h4000, 1'b1, 0, "R2 after refill");
  endtask

  initial begin
    #12 rst_n = 1'b1;
    test_reset();
    test_fill();
    test_lookup();
    test_replace();
    test_wrap();
    test_inv();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule